// File: doc/BRIEF.md
# Vector Lane Shuffle and Mask Unit

This block performs the non-arithmetic data movement and sign-test operations on 256-bit vectors inside a vector execution pipeline. A 4-bit opcode selects one of these operations: replicating a scalar or a 128-bit value, inserting or extracting a 128-bit half, assembling a result from halves of two sources, rearranging 32-bit or 64-bit elements under immediate control, merging memory data under a per-element mask with zero fill, producing byte enables for a masked store, and computing two flags from element sign bits.

Each operation takes one issue cycle. Inputs are sampled on the rising edge at which `in_valid` is high. The result, the byte enables and the flags then appear registered one cycle later together with `out_valid`. The register file, memory access and arithmetic sit outside this block. In mask-driven operations, the most significant bit of each element of `src_a` is that element's mask bit.

Top module: `vec_move_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `result`, `store_be`, `flag_zero` and `flag_carry` are all zero.
- R2: `out_valid` equals `in_valid` delayed by one cycle. The outputs reflect the operation issued in the previous cycle. When `in_valid` is low they hold their values.
- R3: Opcodes 0, 1 and 2 replicate `src_a[31:0]`, `src_a[63:0]` and `src_a[127:0]` respectively into every element of `result`.
- R4: Opcode 3 returns `src_a` with one half replaced by `src_b[127:0]`. `imm[0]`=1 replaces the upper half and `imm[0]`=0 replaces the lower half.
- R5: Opcode 4 places the upper half of `src_a` (`imm[0]`=1) or its lower half (`imm[0]`=0) into `result[127:0]`. `result[255:128]` is zero.
- R6: Opcode 5 builds each result half from a 2-bit selector, where 0 is the low half of `src_a`, 1 is its high half, 2 is the low half of `src_b` and 3 is its high half. `imm[1:0]` drives the low result half and `imm[5:4]` drives the high result half.
- R7: For opcode 5, `imm[3]`=1 forces the low result half to zero and `imm[7]`=1 forces the high result half to zero, whatever the selectors are.
- R8: Opcode 6 rearranges the 32-bit elements of `src_a` separately within each 128-bit lane. Destination element k of a lane takes source element `imm[2k+1:2k]` of the same lane, and both lanes use the same control.
- R9: Opcode 7 rearranges the 64-bit elements of `src_a` within each 128-bit lane. Destination element k takes source element `imm[k]` of the same lane.
- R10: Opcodes 8 (32-bit elements) and 9 (64-bit elements) copy an element from `mem_data` where its mask bit in `src_a` is set. Every other element is zero.
- R11: Opcodes 10 (32-bit) and 11 (64-bit) output `src_b` as the store data. They set the bytes of `store_be` for each element whose mask bit is set and clear the rest; bit j covers byte j of `result`. For every other opcode `store_be` is zero.
- R12: Opcodes 12 (32-bit) and 13 (64-bit) set `flag_zero` when no element sign bit is set in `src_a & src_b`, and set `flag_carry` when none is set in `~src_a & src_b`. The result is zero, and both flags are zero for every other opcode.
- R13: Opcodes 14 and 15 produce a zero result, zero byte enables and clear flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe for the operation on the inputs |
| op | input | 4 | Operation code |
| src_a | input | 256 | First operand; also the mask source |
| src_b | input | 256 | Second operand |
| mem_data | input | 256 | Memory data for masked loads |
| imm | input | 8 | Immediate control byte |
| out_valid | output | 1 | Result valid, one cycle after issue |
| result | output | 256 | Registered vector result |
| store_be | output | 32 | Byte enables for masked stores |
| flag_zero | output | 1 | Sign test: no sign bit in a AND b |
| flag_carry | output | 1 | Sign test: no sign bit in NOT a AND b |

## Verification
The bench sends several hundred random operations, with random opcode, operands and immediate, so every selector code and element swap pattern appears in each lane. Directed cases cover what random data rarely reaches: all-clear and all-set masks, which separate a fully zero-filled load from a full copy and an empty store from a full one; both half-zeroing bits of the permute, set together with non-zero selectors; and operand pairs that drive each flag to each value on its own. Idle cycles with changing inputs show that the outputs hold while nothing is issued.

// File: rtl/vec_move_unit.sv
module vec_move_unit #(
  parameter int VW = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [3:0]      op,
  input  logic [VW-1:0]   src_a,
  input  logic [VW-1:0]   src_b,
  input  logic [VW-1:0]   mem_data,
  input  logic [7:0]      imm,
  output logic            out_valid,
  output logic [VW-1:0]   result,
  output logic [VW/8-1:0] store_be,
  output logic            flag_zero,
  output logic            flag_carry
);
  localparam int HALF  = VW / 2;
  localparam int N32   = VW / 32;
  localparam int N64   = VW / 64;
  localparam int NLANE = VW / 128;

  localparam logic [3:0] OP_BC32 = 4'd0,  OP_BC64 = 4'd1,  OP_BC128 = 4'd2;
  localparam logic [3:0] OP_INS  = 4'd3,  OP_EXT  = 4'd4,  OP_PERM  = 4'd5;
  localparam logic [3:0] OP_SW32 = 4'd6,  OP_SW64 = 4'd7;
  localparam logic [3:0] OP_ML32 = 4'd8,  OP_ML64 = 4'd9;
  localparam logic [3:0] OP_MS32 = 4'd10, OP_MS64 = 4'd11;
  localparam logic [3:0] OP_TS32 = 4'd12, OP_TS64 = 4'd13;

  logic [VW-1:0]   res_d;
  logic [VW/8-1:0] be_d;
  logic            zf_d, cf_d;

  function automatic logic [HALF-1:0] pick_half(input logic [1:0] sel,
                                                input logic [VW-1:0] a,
                                                input logic [VW-1:0] b);
    case (sel)
      2'd0:    return a[0 +: HALF];
      2'd1:    return a[HALF +: HALF];
      2'd2:    return b[0 +: HALF];
      default: return b[HALF +: HALF];
    endcase
  endfunction

  always_comb begin
    res_d = '0;
    be_d  = '0;
    zf_d  = 1'b0;
    cf_d  = 1'b0;
    case (op)
      OP_BC32:  for (int i = 0; i < N32; i++) res_d[32*i +: 32] = src_a[31:0];
      OP_BC64:  for (int i = 0; i < N64; i++) res_d[64*i +: 64] = src_a[63:0];
      OP_BC128: for (int i = 0; i < NLANE; i++) res_d[128*i +: 128] = src_a[127:0];
      OP_INS: begin
        res_d = src_a;
        if (imm[0]) res_d[HALF +: HALF] = src_b[0 +: HALF];
        else        res_d[0 +: HALF]    = src_b[0 +: HALF];
      end
      OP_EXT:
        res_d[0 +: HALF] = imm[0] ? src_a[HALF +: HALF] : src_a[0 +: HALF];
      OP_PERM: begin
        res_d[0 +: HALF]    = imm[3] ? '0 : pick_half(imm[1:0], src_a, src_b);
        res_d[HALF +: HALF] = imm[7] ? '0 : pick_half(imm[5:4], src_a, src_b);
      end
      OP_SW32:
        for (int l = 0; l < NLANE; l++)
          for (int e = 0; e < 4; e++)
            res_d[128*l + 32*e +: 32] = src_a[128*l + 32*int'(imm[2*e +: 2]) +: 32];
      OP_SW64:
        for (int l = 0; l < NLANE; l++)
          for (int e = 0; e < 2; e++)
            res_d[128*l + 64*e +: 64] = src_a[128*l + 64*int'(imm[e]) +: 64];
      OP_ML32:
        for (int i = 0; i < N32; i++)
          if (src_a[32*i + 31]) res_d[32*i +: 32] = mem_data[32*i +: 32];
      OP_ML64:
        for (int i = 0; i < N64; i++)
          if (src_a[64*i + 63]) res_d[64*i +: 64] = mem_data[64*i +: 64];
      OP_MS32: begin
        res_d = src_b;
        for (int i = 0; i < N32; i++) be_d[4*i +: 4] = {4{src_a[32*i + 31]}};
      end
      OP_MS64: begin
        res_d = src_b;
        for (int i = 0; i < N64; i++) be_d[8*i +: 8] = {8{src_a[64*i + 63]}};
      end
      OP_TS32: begin
        zf_d = 1'b1;
        cf_d = 1'b1;
        for (int i = 0; i < N32; i++) begin
          if (src_a[32*i + 31] & src_b[32*i + 31])  zf_d = 1'b0;
          if (!src_a[32*i + 31] & src_b[32*i + 31]) cf_d = 1'b0;
        end
      end
      OP_TS64: begin
        zf_d = 1'b1;
        cf_d = 1'b1;
        for (int i = 0; i < N64; i++) begin
          if (src_a[64*i + 63] & src_b[64*i + 63])  zf_d = 1'b0;
          if (!src_a[64*i + 63] & src_b[64*i + 63]) cf_d = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      store_be   <= '0;
      flag_zero  <= 1'b0;
      flag_carry <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= res_d;
        store_be   <= be_d;
        flag_zero  <= zf_d;
        flag_carry <= cf_d;
      end
    end
  end

  a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 out_valid == $past(in_valid));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(store_be) && $stable(flag_zero) && $stable(flag_carry));

  a_r3_bcast32_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_BC32 |=> result[31:0] == result[VW-1 -: 32]);

  a_r10_load_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op == OP_ML32 || op == OP_ML64) && src_a == '0 |=> result == '0);

  a_r11_no_be_outside_store: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op != OP_MS32 && op != OP_MS64 |=> store_be == '0);

  a_r12_flags_only_on_test: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op != OP_TS32 && op != OP_TS64 |=> !flag_zero && !flag_carry);

  a_r13_unused_op_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op >= 4'd14 |=> result == '0);
endmodule

// File: tb/sim_vec_move_unit.sv
module sim_vec_move_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [3:0]   op = '0;
  logic [255:0] src_a = '0, src_b = '0, mem_data = '0;
  logic [7:0]   imm = '0;
  logic         out_valid;
  logic [255:0] result;
  logic [31:0]  store_be;
  logic         flag_zero, flag_carry;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  vec_move_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .mem_data(mem_data), .imm(imm),
    .out_valid(out_valid), .result(result), .store_be(store_be),
    .flag_zero(flag_zero), .flag_carry(flag_carry)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [127:0] quarter(input logic [255:0] a, input logic [255:0] b,
                                           input logic [1:0] s);
    logic [511:0] all;
    all = {b, a};
    return all[128*s +: 128];
  endfunction

  task automatic model(input logic [3:0] o, input logic [255:0] a, input logic [255:0] b,
                       input logic [255:0] m, input logic [7:0] im,
                       output logic [255:0] r, output logic [31:0] be,
                       output logic zf, output logic cf);
    int idx;
    r = '0; be = '0; zf = 1'b0; cf = 1'b0;
    case (o)
      4'd0: r = {8{a[31:0]}};
      4'd1: r = {4{a[63:0]}};
      4'd2: r = {2{a[127:0]}};
      4'd3: r = im[0] ? {b[127:0], a[127:0]} : {a[255:128], b[127:0]};
      4'd4: r = {128'd0, im[0] ? a[255:128] : a[127:0]};
      4'd5: begin
        r[127:0]   = im[3] ? 128'd0 : quarter(a, b, im[1:0]);
        r[255:128] = im[7] ? 128'd0 : quarter(a, b, im[5:4]);
      end
      4'd6: for (int ln = 0; ln < 2; ln++) for (int k = 0; k < 4; k++) begin
        idx = (im >> (2*k)) & 3;
        r[ln*128 + k*32 +: 32] = a[ln*128 + idx*32 +: 32];
      end
      4'd7: for (int ln = 0; ln < 2; ln++) for (int k = 0; k < 2; k++) begin
        idx = (im >> k) & 1;
        r[ln*128 + k*64 +: 64] = a[ln*128 + idx*64 +: 64];
      end
      4'd8:  for (int k = 0; k < 8; k++) r[k*32 +: 32] = a[k*32+31] ? m[k*32 +: 32] : 32'd0;
      4'd9:  for (int k = 0; k < 4; k++) r[k*64 +: 64] = a[k*64+63] ? m[k*64 +: 64] : 64'd0;
      4'd10: begin r = b; for (int k = 0; k < 8; k++) be[k*4 +: 4] = a[k*32+31] ? 4'hf : 4'h0; end
      4'd11: begin r = b; for (int k = 0; k < 4; k++) be[k*8 +: 8] = a[k*64+63] ? 8'hff : 8'h00; end
      4'd12, 4'd13: begin
        zf = 1'b1; cf = 1'b1;
        for (int k = 0; k < ((o == 4'd12) ? 8 : 4); k++) begin
          idx = (o == 4'd12) ? k*32 + 31 : k*64 + 63;
          if (a[idx] && b[idx])  zf = 1'b0;
          if (!a[idx] && b[idx]) cf = 1'b0;
        end
      end
      default: ;
    endcase
  endtask

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1, 4'd2: return "R3";
      4'd3:             return "R4";
      4'd4:             return "R5";
      4'd5:             return "R6/R7";
      4'd6:             return "R8";
      4'd7:             return "R9";
      4'd8, 4'd9:       return "R10";
      4'd10, 4'd11:     return "R11";
      4'd12, 4'd13:     return "R12";
      default:          return "R13";
    endcase
  endfunction

  task automatic run(input logic [3:0] o, input logic [255:0] a, input logic [255:0] b,
                     input logic [255:0] m, input logic [7:0] im);
    logic [255:0] er; logic [31:0] eb; logic ez, ec;
    string t;
    model(o, a, b, m, im, er, eb, ez, ec);
    t = tag_of(o);
    @(negedge clk);
    op = o; src_a = a; src_b = b; mem_data = m; imm = im; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({"R2 valid ", t}, {255'd0, out_valid}, 256'd1);
    chk({t, " result"}, result, er);
    chk({t, " store_be"}, {224'd0, store_be}, {224'd0, eb});
    chk({t, " flag_zero"}, {255'd0, flag_zero}, {255'd0, ez});
    chk({t, " flag_carry"}, {255'd0, flag_carry}, {255'd0, ec});
  endtask

  task automatic idle_hold();
    logic [255:0] r0; logic [31:0] b0; logic z0, c0;
    r0 = result; b0 = store_be; z0 = flag_zero; c0 = flag_carry;
    @(negedge clk);
    op = 4'd11; src_a = '1; src_b = rnd256(); imm = 8'hff; in_valid = 1'b0;
    @(negedge clk);
    chk("R2 idle valid", {255'd0, out_valid}, 256'd0);
    chk("R2 idle result hold", result, r0);
    chk("R2 idle be hold", {224'd0, store_be}, {224'd0, b0});
    chk("R2 idle flags hold", {254'd0, flag_zero, flag_carry}, {254'd0, z0, c0});
  endtask

  localparam logic [255:0] SIGNS32 = {8{32'h8000_0000}};

  initial begin
    void'($urandom(32'h5eed_1234));
    src_a = '1; src_b = '1; op = 4'd12; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {255'd0, out_valid}, 256'd0);
    chk("R1 reset result", result, 256'd0);
    chk("R1 reset be", {224'd0, store_be}, 256'd0);
    chk("R1 reset flags", {254'd0, flag_zero, flag_carry}, 256'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    run(4'd0, rnd256(), rnd256(), rnd256(), 8'h00);
    run(4'd1, rnd256(), rnd256(), rnd256(), 8'h00);
    run(4'd2, rnd256(), rnd256(), rnd256(), 8'h00);
    run(4'd3, rnd256(), rnd256(), rnd256(), 8'h01);
    run(4'd3, rnd256(), rnd256(), rnd256(), 8'h00);
    run(4'd4, rnd256(), rnd256(), rnd256(), 8'h01);
    run(4'd4, rnd256(), rnd256(), rnd256(), 8'h00);
    run(4'd5, rnd256(), rnd256(), rnd256(), 8'h88);
    run(4'd5, rnd256(), rnd256(), rnd256(), 8'h3b);
    run(4'd5, rnd256(), rnd256(), rnd256(), 8'h92);
    run(4'd6, rnd256(), rnd256(), rnd256(), 8'h1b);
    run(4'd7, rnd256(), rnd256(), rnd256(), 8'h01);
    run(4'd8, 256'd0, rnd256(), rnd256(), 8'h00);
    run(4'd9, '1, rnd256(), rnd256(), 8'h00);
    run(4'd10, 256'd0, rnd256(), rnd256(), 8'h00);
    run(4'd11, '1, rnd256(), rnd256(), 8'h00);
    run(4'd12, 256'd0, SIGNS32, rnd256(), 8'h00);
    run(4'd12, '1, '1, rnd256(), 8'h00);
    run(4'd13, rnd256(), 256'd0, rnd256(), 8'h00);
    run(4'd12, {SIGNS32[255:32], 32'd0}, SIGNS32, rnd256(), 8'h00);
    run(4'd14, rnd256(), rnd256(), rnd256(), 8'hff);
    run(4'd15, rnd256(), rnd256(), rnd256(), 8'h55);
    idle_hold();

    for (int n = 0; n < 400; n++) begin
      run(4'($urandom_range(0, 15)), rnd256(), rnd256(), rnd256(), 8'($urandom));
      if (n % 37 == 0) idle_hold();
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R2 actual=hung expected=complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule